// File: doc/BRIEF.md
# CAN Error Confinement Counter and State Tracker

This block tracks how healthy a CAN node is on the bus. The protocol engine reports four kinds of event, each as a single-cycle pulse: a transmit error, a receive error, a successful transmission and a successful reception. The block keeps a transmit error count and a receive error count, and from them it derives the node's confinement state: error-active, error-passive or bus-off.

Next to the counts it shows a set of flag bits:
- a warning flag per direction;
- a passive flag per direction;
- a bus-off flag;
- a combined warning flag.

It also raises a one-cycle interrupt cause whenever the state changes. A bus-off node can only return to the bus after the bus has shown a long run of idle. A separate detector pulses `idle_run` each time it sees 11 consecutive recessive bits. After 128 such pulses the node recovers with both counts cleared. Detecting the errors themselves is left to the protocol engine.

All pins are plain control and status signals. There is no streaming data path, so there is no valid/ready handshake and no back-pressure. Every input pulse is consumed on the clock edge where it is high. Every count and flag reflects that edge from the following cycle on.

Top module: `can_fault_conf`

## Requirements
- R1: After reset both counts are 0, `state` is 2'b00 (error-active), and every flag and `err_irq` are 0.
- R2: A `tx_err` pulse adds 8 to `tec`. An `rx_err` pulse adds 1 to `rec`, and `rec` saturates at 255.
- R3: A `tx_ok` or `rx_ok` pulse subtracts 1 from the matching count, never going below 0. If an error and a success arrive in the same cycle for the same direction, only the error is applied.
- R4: `tx_warn` is 1 while `tec` is 96 or more, and `rx_warn` is 1 while `rec` is 96 or more. `any_warn` is the OR of the two.
- R5: `tx_passive` and `rx_passive` are 1 while the matching count is 128 or more. Outside bus-off, `state` is 2'b01 (error-passive) while either count is 128 or more, and 2'b00 when both are below 128.
- R6: A `tx_err` that would take `tec` above 255 puts the node in bus-off: `state` becomes 2'b10, `boff_flag` becomes 1 and `tec` is held at 255. While in bus-off, all four event inputs leave both counts unchanged.
- R7: While in bus-off, the 128th `idle_run` pulse clears both counts and returns `state` to 2'b00. `idle_run` pulses seen outside bus-off are not counted toward a later recovery.
- R8: `err_irq` is 1 for exactly the cycle in which `state` first shows a new value, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_err | input | 1 | Transmit error event pulse |
| rx_err | input | 1 | Receive error event pulse |
| tx_ok | input | 1 | Successful transmission pulse |
| rx_ok | input | 1 | Successful reception pulse |
| idle_run | input | 1 | One pulse per 11 consecutive recessive bits |
| tec | output | 8 | Transmit error count |
| rec | output | 8 | Receive error count |
| state | output | 2 | 00 error-active, 01 error-passive, 10 bus-off |
| boff_flag | output | 1 | Node is in bus-off |
| tx_passive | output | 1 | Transmit count at or above 128 |
| rx_passive | output | 1 | Receive count at or above 128 |
| tx_warn | output | 1 | Transmit count at or above 96 |
| rx_warn | output | 1 | Receive count at or above 96 |
| any_warn | output | 1 | Either warning flag set |
| err_irq | output | 1 | State-change interrupt cause, one cycle |

## Verification
The hardest situation to reach is bus-off recovery, and in particular showing that idle-run pulses seen before bus-off are not carried into the recovery count. The stimulus first walks `tec` up by eights through the warning level, the passive level and the overflow. It then checks that 127 idle runs still leave the node in bus-off and that the 128th releases it. Next it sends 130 idle runs while the node is error-active and drives the node back into bus-off. A single further idle run must not release it, and only a full fresh sequence of 128 may.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'b00,
    ST_PASSIVE = 2'b01,
    ST_BUSOFF  = 2'b10
  } cfc_state_e;
endpackage

// File: rtl/cfc_err_counter.sv
module cfc_err_counter #(
  parameter int W    = 8,
  parameter int STEP = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  input  logic         hold,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  localparam int unsigned MAXV = (1 << W) - 1;

  logic [W:0] sum;
  assign sum = {1'b0, cnt} + (W+1)'(STEP);
  assign ovf = inc & ~hold & ~clr & (sum > (W+1)'(MAXV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (hold)                cnt <= cnt;
    else if (inc)                 cnt <= ovf ? W'(MAXV) : sum[W-1:0];
    else if (dec && cnt != '0)    cnt <= cnt - 1'b1;
  end

  // R3
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && !hold && !clr && cnt == '0) |=> cnt == '0);

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !hold && !clr && !ovf) |=> cnt == $past(cnt) + W'(STEP));
endmodule

// File: rtl/cfc_level_flags.sv
module cfc_level_flags #(
  parameter int W        = 8,
  parameter int WARN_LVL = 96,
  parameter int PAS_LVL  = 128
) (
  input  logic [W-1:0] cnt,
  output logic         warn,
  output logic         pas
);
  assign warn = cnt >= W'(WARN_LVL);
  assign pas  = cnt >= W'(PAS_LVL);
endmodule

// File: rtl/cfc_recovery.sv
module cfc_recovery #(
  parameter int RUNS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(RUNS + 1);

  logic [CW-1:0] runs_q;

  assign done = armed & run & (runs_q == CW'(RUNS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              runs_q <= '0;
    else if (!armed || done) runs_q <= '0;
    else if (run)            runs_q <= runs_q + 1'b1;
  end

  // R7
  disarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> runs_q == '0);
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int CNT_W       = 8,
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LVL = 128,
  parameter int TX_STEP     = 8,
  parameter int RX_STEP     = 1,
  parameter int RECOV_RUNS  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err,
  input  logic             rx_err,
  input  logic             tx_ok,
  input  logic             rx_ok,
  input  logic             idle_run,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic [1:0]       state,
  output logic             boff_flag,
  output logic             tx_passive,
  output logic             rx_passive,
  output logic             tx_warn,
  output logic             rx_warn,
  output logic             any_warn,
  output logic             err_irq
);
  import cfc_pkg::*;

  localparam int unsigned CMAX = (1 << CNT_W) - 1;

  logic       boff_q;
  logic       tx_ovf;
  logic       rx_ovf;
  logic       recov_done;
  cfc_state_e state_c;
  cfc_state_e prev_q;

  cfc_err_counter #(.W(CNT_W), .STEP(TX_STEP)) u_tx_cnt (
    .clk(clk), .rst_n(rst_n), .inc(tx_err), .dec(tx_ok),
    .hold(boff_q), .clr(recov_done), .cnt(tec), .ovf(tx_ovf)
  );

  cfc_err_counter #(.W(CNT_W), .STEP(RX_STEP)) u_rx_cnt (
    .clk(clk), .rst_n(rst_n), .inc(rx_err), .dec(rx_ok),
    .hold(boff_q), .clr(recov_done), .cnt(rec), .ovf(rx_ovf)
  );

  cfc_level_flags #(.W(CNT_W), .WARN_LVL(WARN_LVL), .PAS_LVL(PASSIVE_LVL)) u_tx_lvl (
    .cnt(tec), .warn(tx_warn), .pas(tx_passive)
  );

  cfc_level_flags #(.W(CNT_W), .WARN_LVL(WARN_LVL), .PAS_LVL(PASSIVE_LVL)) u_rx_lvl (
    .cnt(rec), .warn(rx_warn), .pas(rx_passive)
  );

  cfc_recovery #(.RUNS(RECOV_RUNS)) u_recov (
    .clk(clk), .rst_n(rst_n), .armed(boff_q), .run(idle_run), .done(recov_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          boff_q <= 1'b0;
    else if (tx_ovf)     boff_q <= 1'b1;
    else if (recov_done) boff_q <= 1'b0;
  end

  always_comb begin
    if (boff_q)                       state_c = ST_BUSOFF;
    else if (tx_passive || rx_passive) state_c = ST_PASSIVE;
    else                              state_c = ST_ACTIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= ST_ACTIVE;
    else        prev_q <= state_c;
  end

  assign state     = state_c;
  assign boff_flag = boff_q;
  assign any_warn  = tx_warn | rx_warn;
  assign err_irq   = (state_c != prev_q);

  // R6
  busoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boff_q && !recov_done) |=> ($stable(tec) && $stable(rec)));

  // R6
  busoff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boff_q) |-> (tec == CNT_W'(CMAX) && $past(tx_err)));

  // R7
  recovery_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recov_done |=> (tec == '0 && rec == '0 && state == 2'b00));

  // R8
  irq_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> state != $past(state));

  // R5
  passive_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!boff_q && (tec >= CNT_W'(PASSIVE_LVL) || rec >= CNT_W'(PASSIVE_LVL)))
      |-> state == 2'b01);
endmodule

// File: tb/can_fault_conf_test.sv
module can_fault_conf_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tx_err, rx_err, tx_ok, rx_ok, idle_run;
  logic [7:0] tec, rec;
  logic [1:0] state;
  logic boff_flag, tx_passive, rx_passive, tx_warn, rx_warn, any_warn, err_irq;

  can_fault_conf uut (
    .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .rx_err(rx_err),
    .tx_ok(tx_ok), .rx_ok(rx_ok), .idle_run(idle_run),
    .tec(tec), .rec(rec), .state(state), .boff_flag(boff_flag),
    .tx_passive(tx_passive), .rx_passive(rx_passive),
    .tx_warn(tx_warn), .rx_warn(rx_warn), .any_warn(any_warn),
    .err_irq(err_irq)
  );

  typedef struct {
    logic [7:0] tec;
    logic [7:0] rec;
    logic [1:0] st;
    logic [5:0] fl;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  int m_tec = 0, m_rec = 0, m_runs = 0;
  bit m_boff = 0;
  logic [1:0] m_prev = 2'b00;

  function automatic logic [5:0] act_flags();
    return {boff_flag, tx_passive, rx_passive, tx_warn, rx_warn, any_warn};
  endfunction

  // Drive one cycle of events and record what the outputs must show after the edge.
  task automatic step(input bit te, input bit re, input bit to, input bit ro,
                      input bit run, input string tag);
    exp_t e;
    logic [1:0] st;
    @(negedge clk);
    tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro; idle_run = run;
    if (m_boff) begin
      if (run) begin
        m_runs++;
        if (m_runs == 128) begin
          m_tec = 0; m_rec = 0; m_boff = 0; m_runs = 0;
        end
      end
    end else begin
      m_runs = 0;
      if (te) begin
        if (m_tec + 8 > 255) begin m_tec = 255; m_boff = 1; end
        else m_tec += 8;
      end else if (to && m_tec > 0) m_tec--;
      if (re) begin
        if (m_rec < 255) m_rec++;
      end else if (ro && m_rec > 0) m_rec--;
    end
    st = m_boff ? 2'b10 : ((m_tec >= 128 || m_rec >= 128) ? 2'b01 : 2'b00);
    e.tec = 8'(m_tec);
    e.rec = 8'(m_rec);
    e.st  = st;
    e.fl  = {m_boff, m_tec >= 128, m_rec >= 128, m_tec >= 96, m_rec >= 96,
             (m_tec >= 96) || (m_rec >= 96)};
    e.irq = (st != m_prev);
    e.tag = tag;
    m_prev = st;
    q.push_back(e);
  endtask

  // Monitor: compare after each active edge against the queued expectation.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (tec !== e.tec || rec !== e.rec || state !== e.st ||
            act_flags() !== e.fl || err_irq !== e.irq) begin
          fails++;
          $display("FAIL %s: tec=%0d rec=%0d st=%b fl=%b irq=%b exp tec=%0d rec=%0d st=%b fl=%b irq=%b",
                   e.tag, tec, rec, state, act_flags(), err_irq,
                   e.tec, e.rec, e.st, e.fl, e.irq);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; idle_run = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    // R1 reset state
    if (tec !== 8'd0 || rec !== 8'd0 || state !== 2'b00 ||
        act_flags() !== 6'b0 || err_irq !== 1'b0) begin
      fails++;
      $display("FAIL R1: tec=%0d rec=%0d st=%b fl=%b irq=%b exp all zero",
               tec, rec, state, act_flags(), err_irq);
    end
    step(0,0,0,0,0,"R1");
    // R2 increments
    repeat (3) step(1,0,0,0,0,"R2");
    repeat (5) step(0,1,0,0,0,"R2");
    // R3 decrements, error wins, floor at zero
    repeat (2) step(0,0,1,0,0,"R3");
    step(1,0,1,0,0,"R3");
    repeat (7) step(0,0,0,1,0,"R3");
    step(0,1,0,1,0,"R3");
    repeat (2) step(0,0,0,1,0,"R3");
    // R4 warning thresholds
    repeat (9) step(1,0,0,0,0,"R4");
    repeat (96) step(0,1,0,0,0,"R4");
    // R5 / R8 passive entry and exit
    repeat (4) step(1,0,0,0,0,"R5_R8");
    repeat (7) step(0,0,1,0,0,"R5_R8");
    // R2 receive saturation, then back to active through rec
    repeat (170) step(0,1,0,0,0,"R2");
    repeat (128) step(0,0,0,1,0,"R5");
    // R6 overflow into bus-off, then ignored events
    repeat (17) step(1,0,0,0,0,"R6");
    repeat (5) step(1,1,1,1,0,"R6");
    step(0,0,1,1,0,"R6");
    // R7 recovery boundary
    repeat (127) step(0,0,0,0,1,"R7");
    step(0,0,0,0,1,"R7_R8");
    // R7 idle runs outside bus-off are not retained
    repeat (130) step(0,0,0,0,1,"R7");
    repeat (32) step(1,0,0,0,0,"R6");
    step(0,0,0,0,1,"R7");
    repeat (127) step(0,0,0,0,1,"R7");
    step(0,0,0,0,0,"R1");
    wait (q.size() == 0);
    @(posedge clk); #3;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule